// File: doc/BRIEF.md
# Dual-Mode PCI Bus Arbiter

This block decides which agent owns one PCI bus segment. A mode pin is captured while reset is held and is frozen when reset is released. In internal mode the block runs its own round-robin arbiter. It serves six active-low request/grant pairs, a south-bridge agent that asks for the bus through an active-low hold line and is answered on an active-low hold-acknowledge line, and the local host side, which asks through `host_req` and is answered on `host_gnt`.

In external mode an outside arbiter owns the bus. Pair zero changes role: the grant-0 pin becomes an active-low host request to that arbiter, and the request-0 pin becomes the arbiter's active-low host grant back to this block. The other five pairs and the hold handshake are switched off. The local host may start a host-to-PCI access only while `host_gnt` is high.

There is no data path, so no valid/ready handshake applies. Every pin is a plain level-sensitive control signal, and every output comes from a register.

Top module: `pci_dual_arbiter`

## Requirements
- R1: `mode_strap_n` is captured on the last rising clock edge at which `rst_n` is low. A 1 selects internal mode and a 0 selects external mode. Changes on the strap while out of reset have no effect until the next reset.
- R2: While `rst_n` is low, every `gnt_n` bit and `hold_ack_n` read 1 and `host_gnt` reads 0, after the first clock edge of reset.
- R3: In internal mode, with the bus idle, a request sampled at a clock edge shows its grant immediately after that same edge. The active-low grant bit i answers request bit i.
- R4: In internal mode, at most one of the `gnt_n` bits, `hold_ack_n` and `host_gnt` is asserted in any cycle.
- R5: When ownership passes from one agent to another, at least one cycle with no grant asserted separates the two grants.
- R6: An owner keeps its grant for as long as it holds its request, even when others are requesting. After the clock edge that samples its request released, its grant is removed.
- R7: Round-robin order is by index: pairs 0 to 5, then hold as index 6, then the local host as index 7. The search starts at the index just past the most recent owner and wraps. After reset the search starts at index 0.
- R8: In internal mode, `hold_n` low is a request at index 6 and is granted by driving `hold_ack_n` low.
- R9: In internal mode, `host_req` high is a request at index 7 and is granted by driving `host_gnt` high.
- R10: In external mode, `req_n[5:1]` are ignored and `gnt_n[5:1]` stay at 1.
- R11: In external mode, `hold_n` is ignored and `hold_ack_n` stays at 1.
- R12: In external mode, `gnt_n[0]` equals the inverse of `host_req` as sampled at the previous clock edge. `host_gnt` is high exactly when the previous edge sampled both `host_req` high and `req_n[0]` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset; the strap is captured while it is low |
| mode_strap_n | input | 1 | Mode strap, low selects external arbitration |
| req_n | input | 6 | Active-low bus requests; in external mode bit 0 is the outside arbiter's host grant |
| gnt_n | output | 6 | Active-low bus grants; in external mode bit 0 is the host request to the outside arbiter |
| hold_n | input | 1 | Active-low bus request from the south-bridge agent |
| hold_ack_n | output | 1 | Active-low grant to the south-bridge agent |
| host_req | input | 1 | Local host side needs the bus for a host-to-PCI access |
| host_gnt | output | 1 | Local host side may use the bus |

## Verification
The assertions assume that the strap is stable for the clock edges of reset that matter. They also assume that every requester keeps its request level until it has been granted or deliberately withdrawn, and that the mode does not change without a reset. The stimulus changes inputs only one time unit after a rising edge and changes the strap only between resets, except for one deliberate toggle that shows the toggle has no effect. Requesters release their request only in a cycle where their grant is visible or where they want to withdraw. As a result, every expected grant pattern follows from the round-robin order and the idle-cycle rule alone.

// File: rtl/pci_arb_pkg.sv
package pci_arb_pkg;
  typedef enum logic {
    MODE_INTERNAL = 1'b0,
    MODE_EXTERNAL = 1'b1
  } arb_mode_e;
endpackage

// File: rtl/pci_arb_mode_latch.sv
module pci_arb_mode_latch
  import pci_arb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      mode_strap_n,
  output arb_mode_e mode
);
  arb_mode_e mode_q;

  // Follow the strap on every edge in reset; the final one wins.
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= mode_strap_n ? MODE_INTERNAL : MODE_EXTERNAL;
  end

  assign mode = mode_q;

  // R1: mode is frozen once reset has been released
  p_mode_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(mode_q));
endmodule

// File: rtl/pci_arb_rr_pick.sv
module pci_arb_rr_pick #(
  parameter int unsigned AGENTS = 8,
  localparam int unsigned AW = $clog2(AGENTS)
) (
  input  logic [AGENTS-1:0] req,
  input  logic [AW-1:0]     last,
  output logic              any,
  output logic [AW-1:0]     win
);
  // Search begins one past the previous owner and wraps around.
  always_comb begin
    int idx;
    any = 1'b0;
    win = last;
    for (int off = 1; off <= int'(AGENTS); off++) begin
      idx = (int'(last) + off) % int'(AGENTS);
      if (!any && req[idx]) begin
        any = 1'b1;
        win = AW'(idx);
      end
    end
  end
endmodule

// File: rtl/pci_arb_grant_ctrl.sv
module pci_arb_grant_ctrl #(
  parameter int unsigned AGENTS = 8,
  localparam int unsigned AW = $clog2(AGENTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [AGENTS-1:0] req,
  output logic [AGENTS-1:0] gnt
);
  logic [AGENTS-1:0] gnt_q;
  logic [AW-1:0]     owner_q;
  logic [AW-1:0]     last_q;
  logic              pick_any;
  logic [AW-1:0]     pick_win;
  logic              busy;
  logic              owner_holds;

  pci_arb_rr_pick #(.AGENTS(AGENTS)) u_pick (
    .req  (req),
    .last (last_q),
    .any  (pick_any),
    .win  (pick_win)
  );

  assign busy        = |gnt_q;
  assign owner_holds = req[owner_q];

  // A new grant is only ever issued from the idle state, so a change of
  // owner always passes through one cycle with nothing granted.
  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      gnt_q   <= '0;
      owner_q <= '0;
      last_q  <= AW'(AGENTS - 1);
    end else if (busy) begin
      if (!owner_holds) begin
        gnt_q  <= '0;
        last_q <= owner_q;
      end
    end else if (pick_any) begin
      gnt_q   <= AGENTS'(1) << pick_win;
      owner_q <= pick_win;
    end
  end

  assign gnt = gnt_q;

  // R5: a live grant either persists unchanged or falls to idle
  p_idle_gap_r5: assert property (@(posedge clk) disable iff (!rst_n || !enable)
    busy |=> (gnt_q == '0) || (gnt_q == $past(gnt_q)));

  // R6: owner that still requests keeps the bus
  p_owner_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n || !enable)
    (busy && |(gnt_q & req)) |=> (gnt_q == $past(gnt_q)));

  // R6: owner that released is dropped on the next edge
  p_owner_drops_r6: assert property (@(posedge clk) disable iff (!rst_n || !enable)
    (busy && !(|(gnt_q & req))) |=> (gnt_q == '0));

  // R3: an idle bus with a requester is granted on the next edge
  p_idle_serves_r3: assert property (@(posedge clk) disable iff (!rst_n || !enable)
    (!busy && |req) |=> (|gnt_q));
endmodule

// File: rtl/pci_arb_ext_link.sv
module pci_arb_ext_link (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic host_req,
  input  logic ext_gnt_pin_n,
  output logic ext_req_pin_n,
  output logic host_gnt
);
  logic hreq_q;
  logic xgnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      hreq_q <= 1'b0;
      xgnt_q <= 1'b0;
    end else begin
      hreq_q <= host_req;
      xgnt_q <= host_req && !ext_gnt_pin_n;
    end
  end

  assign ext_req_pin_n = ~hreq_q;
  assign host_gnt      = xgnt_q;

  // R12: a local need shows up on the request pin one edge later
  p_req_follows_r12: assert property (@(posedge clk) disable iff (!rst_n || !enable)
    host_req |=> !ext_req_pin_n);

  // R12: no local grant without the outside arbiter's grant
  p_gnt_needs_pin_r12: assert property (@(posedge clk) disable iff (!rst_n || !enable)
    ext_gnt_pin_n |=> !host_gnt);
endmodule

// File: rtl/pci_dual_arbiter.sv
module pci_dual_arbiter
  import pci_arb_pkg::*;
#(
  parameter int unsigned NUM_PCI = 6,
  localparam int unsigned AGENTS   = NUM_PCI + 2,
  localparam int unsigned HOLD_IDX = NUM_PCI,
  localparam int unsigned HOST_IDX = NUM_PCI + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_strap_n,
  input  logic [NUM_PCI-1:0] req_n,
  output logic [NUM_PCI-1:0] gnt_n,
  input  logic               hold_n,
  output logic               hold_ack_n,
  input  logic               host_req,
  output logic               host_gnt
);
  arb_mode_e         mode;
  logic              ext;
  logic [AGENTS-1:0] req_vec;
  logic [AGENTS-1:0] gnt_vec;
  logic              ext_req_pin_n;
  logic              ext_host_gnt;

  pci_arb_mode_latch u_mode (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_strap_n (mode_strap_n),
    .mode         (mode)
  );

  assign ext     = (mode == MODE_EXTERNAL);
  assign req_vec = {host_req, ~hold_n, ~req_n};

  pci_arb_grant_ctrl #(.AGENTS(AGENTS)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (!ext),
    .req    (req_vec),
    .gnt    (gnt_vec)
  );

  pci_arb_ext_link u_ext (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (ext),
    .host_req      (host_req),
    .ext_gnt_pin_n (req_n[0]),
    .ext_req_pin_n (ext_req_pin_n),
    .host_gnt      (ext_host_gnt)
  );

  // Pair zero is shared between the two modes; the rest go quiet outside.
  assign gnt_n[0] = ext ? ext_req_pin_n : ~gnt_vec[0];

  for (genvar i = 1; i < int'(NUM_PCI); i++) begin : g_pair
    assign gnt_n[i] = ext ? 1'b1 : ~gnt_vec[i];
  end

  assign hold_ack_n = ext ? 1'b1 : ~gnt_vec[HOLD_IDX];
  assign host_gnt   = ext ? ext_host_gnt : gnt_vec[HOST_IDX];

  // R4: single owner at the pins in internal mode
  p_one_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ext |-> $onehot0({~gnt_n, ~hold_ack_n, host_gnt}));

  // R10: upper pairs stay quiet in external mode
  p_ext_pairs_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ext |-> (&gnt_n[NUM_PCI-1:1]));

  // R11: hold handshake is dead in external mode
  p_ext_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ext |-> hold_ack_n);
endmodule

// File: tb/pci_dual_arbiter_tb.sv
module pci_dual_arbiter_tb;
  localparam time CLK_HALF = 4ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_strap_n = 1'b1;
  logic [5:0] req_n = 6'h3f;
  logic [5:0] gnt_n;
  logic       hold_n = 1'b1;
  logic       hold_ack_n;
  logic       host_req = 1'b0;
  logic       host_gnt;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    int         when;
    logic [5:0] g;
    logic       h;
    logic       hg;
    string      tag;
  } exp_t;
  exp_t sbq[$];

  always #(CLK_HALF) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pci_dual_arbiter u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_strap_n (mode_strap_n),
    .req_n        (req_n),
    .gnt_n        (gnt_n),
    .hold_n       (hold_n),
    .hold_ack_n   (hold_ack_n),
    .host_req     (host_req),
    .host_gnt     (host_gnt)
  );

  task automatic step(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  // Driver side: queue what the pins must show 'dly' cycles from now.
  task automatic expect_at(int dly, logic [5:0] g, logic h, logic hg, string tag);
    exp_t e;
    e.when = cyc + dly;
    e.g = g;
    e.h = h;
    e.hg = hg;
    e.tag = tag;
    sbq.push_back(e);
  endtask

  // Monitor: compare at the falling edge, well away from the active edge.
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].when <= cyc) begin
      exp_t e;
      e = sbq.pop_front();
      checks++;
      if (e.when != cyc || gnt_n !== e.g || hold_ack_n !== e.h || host_gnt !== e.hg) begin
        failures++;
        $display("FAIL %s cyc=%0d actual gnt_n=%b hold_ack_n=%b host_gnt=%b expected gnt_n=%b hold_ack_n=%b host_gnt=%b",
                 e.tag, cyc, gnt_n, hold_ack_n, host_gnt, e.g, e.h, e.hg);
      end
    end
  end

  task automatic do_reset(logic strap);
    rst_n = 1'b0;
    mode_strap_n = strap;
    req_n = 6'h3f;
    hold_n = 1'b1;
    host_req = 1'b0;
    step(2);
    expect_at(0, 6'h3f, 1'b1, 1'b0, "R2 reset quiet");
    step(2);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_HALF * 2 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // ---------------- internal mode ----------------
    do_reset(1'b1);
    step(1);

    // R3/R6: lone request on pair 2
    req_n[2] = 1'b0;
    expect_at(1, 6'b111011, 1'b1, 1'b0, "R3 lone grant pair2");
    expect_at(2, 6'b111011, 1'b1, 1'b0, "R6 grant held pair2");
    step(2);
    req_n[2] = 1'b1;
    expect_at(1, 6'h3f, 1'b1, 1'b0, "R6 release pair2");
    step(2);

    // R7/R5: pairs 0,1,4 together after owner 2 -> 4,0,1
    req_n[0] = 1'b0; req_n[1] = 1'b0; req_n[4] = 1'b0;
    expect_at(1, 6'b101111, 1'b1, 1'b0, "R7 first after 2 is 4");
    step(1);
    req_n[4] = 1'b1;
    expect_at(1, 6'h3f, 1'b1, 1'b0, "R5 idle gap after 4");
    expect_at(2, 6'b111110, 1'b1, 1'b0, "R7 wrap to 0");
    step(2);
    req_n[0] = 1'b1;
    expect_at(1, 6'h3f, 1'b1, 1'b0, "R5 idle gap after 0");
    expect_at(2, 6'b111101, 1'b1, 1'b0, "R7 then 1 R4 single");
    step(2);
    req_n[1] = 1'b1;
    step(2);

    // R8/R9: hold and host together after owner 1 -> hold first
    hold_n = 1'b0;
    host_req = 1'b1;
    expect_at(1, 6'h3f, 1'b0, 1'b0, "R8 hold ack");
    step(1);
    hold_n = 1'b1;
    expect_at(1, 6'h3f, 1'b1, 1'b0, "R5 idle after hold");
    expect_at(2, 6'h3f, 1'b1, 1'b1, "R9 host grant");
    step(2);
    host_req = 1'b0;
    expect_at(1, 6'h3f, 1'b1, 1'b0, "R6 host release");
    step(2);

    // R6: owner 3 keeps the bus while 5 waits
    req_n[3] = 1'b0;
    expect_at(1, 6'b110111, 1'b1, 1'b0, "R3 grant pair3");
    step(1);
    req_n[5] = 1'b0;
    expect_at(1, 6'b110111, 1'b1, 1'b0, "R6 pair3 kept");
    expect_at(2, 6'b110111, 1'b1, 1'b0, "R6 pair3 kept again");
    step(2);
    req_n[3] = 1'b1;
    expect_at(1, 6'h3f, 1'b1, 1'b0, "R5 idle before 5");
    expect_at(2, 6'b011111, 1'b1, 1'b0, "R7 pair5 next");
    step(2);
    req_n[5] = 1'b1;
    step(2);

    // ---------------- external mode ----------------
    do_reset(1'b0);
    step(1);
    mode_strap_n = 1'b1;  // R1: late strap change must not matter
    req_n[5:1] = 5'b00000;
    hold_n = 1'b0;
    expect_at(1, 6'h3f, 1'b1, 1'b0, "R10 R11 R1 ext ignores pairs and hold");
    expect_at(3, 6'h3f, 1'b1, 1'b0, "R1 strap change ignored");
    step(3);

    host_req = 1'b1;
    expect_at(1, 6'b111110, 1'b1, 1'b0, "R12 host request out");
    step(1);
    req_n[0] = 1'b0;
    expect_at(1, 6'b111110, 1'b1, 1'b1, "R12 host grant in");
    step(1);
    host_req = 1'b0;
    expect_at(1, 6'h3f, 1'b1, 1'b0, "R12 request withdrawn");
    expect_at(2, 6'h3f, 1'b1, 1'b0, "R12 no grant without need");
    step(3);
    req_n = 6'h3f;
    hold_n = 1'b1;
    step(1);

    // ---------------- back to internal ----------------
    do_reset(1'b1);
    step(1);
    req_n[1] = 1'b0;
    expect_at(1, 6'b111101, 1'b1, 1'b0, "R1 internal again pair1");
    step(2);
    req_n[1] = 1'b1;
    step(3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule